// File: doc/BRIEF.md
# Legacy Interrupt Request Front End

This block sits between two asynchronous external interrupt pins and an instruction sequencer. It decides when an interrupt is presented to the core and with which vector. A configuration bit selects the mode. With local-APIC routing disabled, pin 0 is a level-sensitive maskable request and pin 1 is an edge-sensitive non-maskable request. With routing enabled, both synchronized pins go straight to a local-APIC port and the block does not arbitrate.

A non-maskable request is captured on a rising edge and carries the fixed vector 2. No acknowledge cycle is run for it. While its handler runs, at most one further edge is held pending, and that edge is delivered after the return strobe. A maskable request is taken only at an instruction boundary with the interrupt-enable flag set. It runs a single acknowledge handshake that returns the vector byte. The request is taken only if the pin is still high when the acknowledge completes.

Top module: `irq_front_end`

## Requirements
- R1: Each pin passes through a two-stage synchronizer. With `apic_en_i`=1, `lint_o[1:0]` equals `pin_i[1:0]` as sampled two clock edges earlier.
- R2: With `apic_en_i`=0, `lint_o` is 0. `pin_i[0]` is the maskable request and `pin_i[1]` is the non-maskable request.
- R3: A non-maskable request is captured only on a 0-to-1 transition of synchronized `pin_i[1]`. A level held high produces no further request.
- R4: Taking a non-maskable request pulses `irq_take_o` for one cycle with `irq_vec_o`=2 and sets `in_nmi_o` in the same cycle. It never raises `ack_req_o`.
- R5: `in_nmi_o` stays high until `nmi_ret_i` is sampled high, and it is low from the next cycle.
- R6: While `in_nmi_o` is high, one captured edge is held pending. It is taken at the first boundary after the return strobe. Further edges captured while one is pending are discarded.
- R7: An acknowledge starts only in a cycle with `insn_bound_i`=1, `if_flag_i`=1, synchronized `pin_i[0]` high and no acknowledge in flight.
- R8: `ack_req_o` rises one cycle after the start. It stays high until `ack_done_i` is sampled high, and it is low the cycle after. Each start produces exactly one acknowledge.
- R9: When the acknowledge completes with synchronized `pin_i[0]` still high, the next cycle pulses `irq_take_o` with `irq_vec_o` equal to the `ack_vec_i` sampled at completion. If the pin is low by then, no take occurs.
- R10: When both requests are ready at the same boundary, the non-maskable one is taken and no acknowledge starts. A non-maskable request is not taken while an acknowledge is in flight.
- R11: With `rst_ni` low, `ack_req_o`, `irq_take_o`, `irq_vec_o`, `in_nmi_o` and all synchronizer and pending state are 0.
- R12: With `apic_en_i`=1, no edge is captured, any pending request is dropped, no acknowledge starts and no take happens.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pin_i | input | 2 | Asynchronous interrupt pins |
| apic_en_i | input | 1 | Route pins to the local-APIC port |
| if_flag_i | input | 1 | Interrupt-enable flag |
| insn_bound_i | input | 1 | Instruction boundary strobe |
| nmi_ret_i | input | 1 | Return-from-NMI strobe |
| ack_done_i | input | 1 | Acknowledge completion |
| ack_vec_i | input | 8 | Vector returned by the acknowledge |
| ack_req_o | output | 1 | Acknowledge request |
| irq_take_o | output | 1 | Interrupt taken pulse |
| irq_vec_o | output | 8 | Vector of the taken interrupt |
| in_nmi_o | output | 1 | NMI handler in progress |
| lint_o | output | 2 | Synchronized pins to the local-APIC port |

## Verification
The hardest case to reach is a second and a third NMI edge arriving inside one handler, followed by the return strobe. The pin must drop for long enough to pass through the synchronizer before it rises again. A directed sequence therefore pulses pin 1 low and high twice while the handler flag is set, returns, and checks that exactly one extra take follows. A random phase toggles the pins, the boundary, the return strobe and the acknowledge replies. Its results are compared every cycle with a bench model derived from the requirements.

// File: rtl/irq_fe_pkg.sv
package irq_fe_pkg;
  localparam int unsigned VEC_W       = 8;
  localparam int unsigned SYNC_STAGES = 2;
  localparam logic [VEC_W-1:0] NMI_VEC = VEC_W'(2);
  localparam int unsigned PIN_INTR = 0;
  localparam int unsigned PIN_NMI  = 1;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int unsigned W      = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] st_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) st_q[g] <= '0;
      else if (g == 0) st_q[g] <= d_i;
      else st_q[g] <= st_q[(g == 0) ? 0 : g-1];
    end
  end

  assign q_o = st_q[STAGES-1];
endmodule

// File: rtl/nmi_ctrl.sv
module nmi_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  input  logic en_i,
  input  logic bound_i,
  input  logic hold_i,
  input  logic ret_i,
  output logic go_o,
  output logic in_nmi_o
);
  logic prev_q, pend_q, in_q;
  logic rise;

  assign rise = en_i & lvl_i & ~prev_q;
  assign go_o = en_i & bound_i & pend_q & ~in_q & ~hold_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b0;
      pend_q <= 1'b0;
      in_q   <= 1'b0;
    end else begin
      prev_q <= lvl_i;
      // one-deep: a second edge while pending merges into it
      pend_q <= en_i & (rise | (pend_q & ~go_o));
      in_q   <= go_o | (in_q & ~ret_i);
    end
  end

  assign in_nmi_o = in_q;
endmodule

// File: rtl/intr_ack.sv
module intr_ack #(
  parameter int unsigned VEC_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             lvl_i,
  input  logic             en_i,
  input  logic             bound_i,
  input  logic             if_i,
  input  logic             nmi_go_i,
  input  logic             done_i,
  input  logic [VEC_W-1:0] vec_i,
  output logic             busy_o,
  output logic             take_o,
  output logic [VEC_W-1:0] vec_o
);
  logic busy_q, start;

  assign start  = en_i & bound_i & if_i & lvl_i & ~busy_q & ~nmi_go_i;
  assign take_o = busy_q & done_i & lvl_i & en_i;
  assign vec_o  = vec_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) busy_q <= 1'b0;
    else busy_q <= start | (busy_q & ~done_i);
  end

  assign busy_o = busy_q;
endmodule

// File: rtl/irq_front_end.sv
module irq_front_end
  import irq_fe_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       pin_i,
  input  logic             apic_en_i,
  input  logic             if_flag_i,
  input  logic             insn_bound_i,
  input  logic             nmi_ret_i,
  input  logic             ack_done_i,
  input  logic [VEC_W-1:0] ack_vec_i,
  output logic             ack_req_o,
  output logic             irq_take_o,
  output logic [VEC_W-1:0] irq_vec_o,
  output logic             in_nmi_o,
  output logic [1:0]       lint_o
);
  logic [1:0]       pin_s;
  logic             legacy, nmi_go, ack_busy, intr_take;
  logic [VEC_W-1:0] intr_vec;
  logic             take_q;
  logic [VEC_W-1:0] vec_q;

  assign legacy = ~apic_en_i;

  irq_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .d_i(pin_i), .q_o(pin_s)
  );

  nmi_ctrl u_nmi (
    .clk_i, .rst_ni,
    .lvl_i(pin_s[PIN_NMI]), .en_i(legacy), .bound_i(insn_bound_i),
    .hold_i(ack_busy), .ret_i(nmi_ret_i),
    .go_o(nmi_go), .in_nmi_o(in_nmi_o)
  );

  intr_ack #(.VEC_W(VEC_W)) u_ack (
    .clk_i, .rst_ni,
    .lvl_i(pin_s[PIN_INTR]), .en_i(legacy), .bound_i(insn_bound_i),
    .if_i(if_flag_i), .nmi_go_i(nmi_go), .done_i(ack_done_i), .vec_i(ack_vec_i),
    .busy_o(ack_busy), .take_o(intr_take), .vec_o(intr_vec)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      take_q <= 1'b0;
      vec_q  <= '0;
    end else begin
      take_q <= nmi_go | intr_take;
      if (nmi_go) vec_q <= NMI_VEC;
      else if (intr_take) vec_q <= intr_vec;
    end
  end

  assign ack_req_o  = ack_busy;
  assign irq_take_o = take_q;
  assign irq_vec_o  = vec_q;
  assign lint_o     = apic_en_i ? pin_s : 2'b00;
endmodule

// File: rtl/irq_front_end_chk.sv
module irq_front_end_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [1:0] pin_i,
  input logic       apic_en_i,
  input logic       if_flag_i,
  input logic       insn_bound_i,
  input logic       nmi_ret_i,
  input logic       ack_done_i,
  input logic [7:0] ack_vec_i,
  input logic       ack_req_o,
  input logic       irq_take_o,
  input logic [7:0] irq_vec_o,
  input logic       in_nmi_o,
  input logic [1:0] lint_o
);
  logic [1:0] cyc_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cyc_q <= '0;
    else if (cyc_q != 2'd3) cyc_q <= cyc_q + 2'd1;
  end

  a_r1_lint_delay: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q >= 2'd2 && apic_en_i) |-> lint_o == $past(pin_i, 2));
  a_r2_lint_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !apic_en_i |-> lint_o == 2'b00);
  a_r4_nmi_vector: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(in_nmi_o) |-> (irq_take_o && irq_vec_o == 8'd2 && !ack_req_o));
  a_r5_ret_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_nmi_o && nmi_ret_i) |=> !in_nmi_o);
  a_r5_nmi_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_nmi_o && !nmi_ret_i) |=> in_nmi_o);
  a_r7_ack_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ack_req_o) |-> $past(if_flag_i && insn_bound_i));
  a_r8_ack_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_req_o && !ack_done_i) |=> ack_req_o);
  a_r8_ack_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_req_o && ack_done_i) |=> !ack_req_o);
  a_r9_take_after_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_take_o && !$rose(in_nmi_o)) |-> ($past(ack_req_o && ack_done_i) && irq_vec_o == $past(ack_vec_i)));
  a_r10_single_winner: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !($rose(ack_req_o) && $rose(in_nmi_o)));
  a_r12_apic_no_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ack_req_o) |-> !$past(apic_en_i));
endmodule

bind irq_front_end irq_front_end_chk u_chk (.*);

// File: tb/irq_front_end_bench.sv
`timescale 1ns/1ps
module irq_front_end_bench;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [1:0] pin_i = 2'b00;
  logic       apic_en_i = 1'b0, if_flag_i = 1'b0, insn_bound_i = 1'b0;
  logic       nmi_ret_i = 1'b0, ack_done_i = 1'b0;
  logic [7:0] ack_vec_i = 8'h00;
  logic       ack_req_o, irq_take_o, in_nmi_o;
  logic [7:0] irq_vec_o;
  logic [1:0] lint_o;

  int n_run = 0, n_fail = 0;
  int n_take = 0, n_ack = 0;
  logic [7:0] last_vec = 8'h00;
  logic ack_prev = 1'b0;
  bit model_on = 1'b0;

  always #5 clk = ~clk;

  irq_front_end u_irq_front_end (
    .clk_i(clk), .rst_ni, .pin_i, .apic_en_i, .if_flag_i, .insn_bound_i,
    .nmi_ret_i, .ack_done_i, .ack_vec_i, .ack_req_o, .irq_take_o,
    .irq_vec_o, .in_nmi_o, .lint_o
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // reference model of the requirements
  logic [1:0] m_s1, m_s2;
  logic m_prev, m_pend, m_in, m_busy, m_take;
  logic [7:0] m_vec;

  function automatic logic nmi_ready(input logic pend, input logic in_h, input logic busy);
    return ~apic_en_i & insn_bound_i & pend & ~in_h & ~busy;
  endfunction

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_s1 = 0; m_s2 = 0; m_prev = 0; m_pend = 0; m_in = 0;
      m_busy = 0; m_take = 0; m_vec = 0;
    end else begin
      logic go, lvl, start, done, rise;
      go    = nmi_ready(m_pend, m_in, m_busy);
      lvl   = m_s2[0] & ~apic_en_i;
      rise  = ~apic_en_i & m_s2[1] & ~m_prev;
      start = ~apic_en_i & insn_bound_i & if_flag_i & lvl & ~m_busy & ~go;
      done  = m_busy & ack_done_i;
      m_take = go | (done & lvl);
      if (go) m_vec = 8'd2;
      else if (done & lvl) m_vec = ack_vec_i;
      m_busy = start | (m_busy & ~ack_done_i);
      m_in   = go | (m_in & ~nmi_ret_i);
      m_pend = ~apic_en_i & (rise | (m_pend & ~go));
      m_prev = m_s2[1];
      m_s2 = m_s1;
      m_s1 = pin_i;
    end
  end

  always @(negedge clk) begin
    if (rst_ni) begin
      ack_prev <= ack_req_o;
      if (irq_take_o) begin n_take++; last_vec = irq_vec_o; end
      if (ack_req_o && !ack_prev) n_ack++;
      if (model_on) begin
        chk(ack_req_o == m_busy, "R8 ack_req model", ack_req_o, m_busy);
        chk(irq_take_o == m_take, "R4/R9 take model", irq_take_o, m_take);
        if (m_take) chk(irq_vec_o == m_vec, "R9 vector model", irq_vec_o, m_vec);
        chk(in_nmi_o == m_in, "R5 in_nmi model", in_nmi_o, m_in);
        chk(lint_o == (apic_en_i ? m_s2 : 2'b00), "R1 lint model", lint_o,
            apic_en_i ? m_s2 : 2'b00);
      end
    end
  end

  task automatic step(input int n = 1);
    repeat (n) begin @(negedge clk); #1; end
  endtask

  task automatic do_ack(input logic [7:0] v);
    int guard = 0;
    while (!ack_req_o && guard < 20) begin step(); guard++; end
    insn_bound_i = 0;
    step(2);
    ack_done_i = 1; ack_vec_i = v;
    step();
    ack_done_i = 0;
    step(3);
  endtask

  task automatic run_all();
    int t0, a0;
    // R11 reset state
    step(3);
    chk(!ack_req_o && !irq_take_o && !in_nmi_o && irq_vec_o == 0 && lint_o == 0,
        "R11 reset outputs", {ack_req_o, irq_take_o, in_nmi_o}, 0);
    rst_ni = 1; model_on = 1;
    step(2);

    // R1 R12: APIC passthrough, no arbitration
    apic_en_i = 1; if_flag_i = 1; insn_bound_i = 1; pin_i = 2'b11;
    t0 = n_take; a0 = n_ack;
    step(4);
    chk(lint_o == 2'b11, "R1 lint passthrough", lint_o, 3);
    pin_i = 2'b10; step(3);
    chk(lint_o == 2'b10, "R1 lint follows pin", lint_o, 2);
    chk(n_take == t0 && n_ack == a0, "R12 no take in APIC mode", n_take - t0, 0);

    // R2: legacy, lint quiet; pin1 already high -> no edge
    pin_i = 2'b00; apic_en_i = 0; insn_bound_i = 0; if_flag_i = 0;
    step(4);
    chk(lint_o == 2'b00, "R2 lint low in legacy", lint_o, 0);

    // R3 R4: edge, then long high level
    insn_bound_i = 1; t0 = n_take; a0 = n_ack;
    pin_i[1] = 1; step(20);
    chk(n_take - t0 == 1, "R3 single take per edge", n_take - t0, 1);
    chk(last_vec == 8'd2, "R4 nmi vector", last_vec, 2);
    chk(n_ack == a0, "R4 no ack for nmi", n_ack - a0, 0);
    chk(in_nmi_o == 1, "R5 in_nmi set", in_nmi_o, 1);

    // R6: two more edges inside handler
    t0 = n_take;
    repeat (2) begin pin_i[1] = 0; step(4); pin_i[1] = 1; step(4); end
    chk(n_take == t0, "R6 no take inside handler", n_take - t0, 0);
    nmi_ret_i = 1; step(); nmi_ret_i = 0;
    step(8);
    chk(n_take - t0 == 1, "R6 pending delivered after return", n_take - t0, 1);
    nmi_ret_i = 1; step(); nmi_ret_i = 0;
    step(8);
    chk(n_take - t0 == 1, "R6 extra edges discarded", n_take - t0, 1);
    chk(in_nmi_o == 0, "R5 in_nmi cleared", in_nmi_o, 0);
    pin_i[1] = 0; step(4);

    // R7: INTR masked by IF
    pin_i[0] = 1; if_flag_i = 0; insn_bound_i = 1; a0 = n_ack;
    step(10);
    chk(n_ack == a0 && !ack_req_o, "R7 masked by IF", n_ack - a0, 0);
    insn_bound_i = 0; if_flag_i = 1; step(6);
    chk(n_ack == a0, "R7 waits for boundary", n_ack - a0, 0);
    // R8 R9: one ack, vector returned
    t0 = n_take; insn_bound_i = 1;
    do_ack(8'h41);
    chk(n_ack - a0 == 1, "R8 exactly one ack", n_ack - a0, 1);
    chk(n_take - t0 == 1 && last_vec == 8'h41, "R9 take with ack vector", last_vec, 8'h41);

    // R9: pin dropped before ack completes
    t0 = n_take; insn_bound_i = 1;
    while (!ack_req_o) step();
    insn_bound_i = 0; pin_i[0] = 0; step(5);
    ack_done_i = 1; ack_vec_i = 8'h77; step(); ack_done_i = 0; step(3);
    chk(n_take == t0, "R9 dropped request not taken", n_take - t0, 0);
    chk(!ack_req_o, "R8 ack released", ack_req_o, 0);

    // R10: both ready at one boundary
    if_flag_i = 1; insn_bound_i = 0; pin_i = 2'b11; step(6);
    t0 = n_take; a0 = n_ack;
    insn_bound_i = 1; step(); insn_bound_i = 0; step(4);
    chk(n_take - t0 == 1 && last_vec == 8'd2, "R10 nmi wins", last_vec, 2);
    chk(n_ack == a0, "R10 no ack at same boundary", n_ack - a0, 0);
    nmi_ret_i = 1; step(); nmi_ret_i = 0;
    insn_bound_i = 1; do_ack(8'h20);
    pin_i = 2'b00; step(4);

    // random phase, checked by the model every cycle
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(9) == 0) pin_i[0] = ~pin_i[0];
      if ($urandom_range(9) == 0) pin_i[1] = ~pin_i[1];
      if ($urandom_range(49) == 0) apic_en_i = ~apic_en_i;
      if_flag_i    = ($urandom_range(9) < 7);
      insn_bound_i = ($urandom_range(9) < 4);
      nmi_ret_i    = ($urandom_range(19) == 0);
      ack_done_i   = ack_req_o && ($urandom_range(9) < 4);
      ack_vec_i    = 8'($urandom);
      step();
    end
  endtask

  initial begin
    process::self().srandom(32'h1A2B);
    fork
      run_all();
      begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule